// File: doc/BRIEF.md
# Receive Descriptor Status Writeback

This block sits beside the receive DMA of an Ethernet MAC. It counts the bytes of each incoming frame against the two buffers of the descriptor currently in use, decides when a frame has to move on to a further descriptor, and composes the 32-bit status word. It then returns each descriptor to the host through a single write request. The receive path supplies one byte per accepted cycle and a separate end-of-frame cycle that carries the frame's flags. A fetch unit supplies descriptors on request, each with an ownership flag and two buffer byte counts.

A descriptor that fills before the frame ends goes back to the host as an intermediate descriptor, and the frame continues in the next one. The frame-level fields appear only in the word of the frame's final descriptor. If the next descriptor still belongs to the host, the frame is cut off. The current descriptor then closes the frame with a descriptor-error mark, and the rest of the frame is discarded up to its end.

Top module: `rx_desc_status_wb`

## Requirements
- R1: Bit 31 (ownership) is 0 in every status word presented on `wb_status` while `wb_vld` is high.
- R2: The final descriptor's word carries in bits 30:16 the number of frame bytes stored, CRC bytes included. Bit 10 is the multicast flag. Bits 13:12 carry the data type: 00 normal, 01 MAC loop-back, 10 transceiver loop-back, 11 remote loop-back.
- R3: In the final word, bit 0 is overflow, bit 1 is CRC error, bit 6 is late collision and bit 7 is frame too long. Bit 15 is the OR of bits 0, 1, 6, 7, 11 and 14, and bits 2-5, 8 and 9 are zero.
- R4: Bit 11 (runt) is set when the stored length is below RUNT_MIN (64 by default), and it is clear at exactly RUNT_MIN.
- R5: The capacity of a descriptor is buffer 1 count plus buffer 2 count. A frame that ends exactly at that capacity uses one descriptor, and only a byte beyond the capacity requests another descriptor.
- R6: A descriptor that a frame leaves for the next one is written back as an all-zero word. The length keeps counting across descriptors.
- R7: If the descriptor fetched for a continuing frame has ownership 0, the current descriptor is written as final with bits 14 and 15 set and the stored length. The rest of the frame is then dropped, the flags at its end are ignored, and the next frame starts in a fresh descriptor.
- R8: While waiting for a descriptor to start a frame, a descriptor offered with ownership 0 is skipped. `dsc_req` stays high, `rx_rdy` stays low, and no writeback occurs.
- R9: The length field saturates at 32767.
- R10: `wb_vld` stays high with an unchanged `wb_status` until `wb_ack`, and it falls in the cycle after the acknowledge.
- R11: After reset, `wb_vld` and `rx_rdy` are low and `dsc_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte_vld | input | 1 | One frame byte offered this cycle |
| rx_eof | input | 1 | End of frame (carries no byte; flags below valid) |
| rx_ovf | input | 1 | Receive overflow flag, valid with rx_eof |
| rx_crc_err | input | 1 | CRC error flag, valid with rx_eof |
| rx_late_col | input | 1 | Late collision flag, valid with rx_eof |
| rx_too_long | input | 1 | Frame too long flag, valid with rx_eof |
| rx_mcast | input | 1 | Multicast frame flag, valid with rx_eof |
| rx_lb_type | input | 2 | Data type code, valid with rx_eof |
| rx_rdy | output | 1 | Bytes and end of frame are accepted this cycle |
| dsc_req | output | 1 | Request for a descriptor |
| dsc_vld | input | 1 | Descriptor offered this cycle |
| dsc_own | input | 1 | Offered descriptor belongs to the controller |
| dsc_b1_cnt | input | BCNT_W | Buffer 1 byte count |
| dsc_b2_cnt | input | BCNT_W | Buffer 2 byte count |
| wb_vld | output | 1 | Status writeback request |
| wb_status | output | 32 | Status word to write |
| wb_ack | input | 1 | Writeback accepted |

## Verification
The bench builds the block with BCNT_W set to 15 and RUNT_MIN left at 64. The wide count fields let a single descriptor hold more than 32767 bytes, so the saturation of the length field can be reached without spilling. Small capacities in other tests force frames across several descriptors and into exhaustion. Capacities of 64 and frames of 63 and 64 bytes place the runt and exact-fit boundaries on the same edge.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   localparam int LEN_W = 15;

   // status word bit positions; the host decodes these
   localparam int P_OVF   = 0;
   localparam int P_CRC   = 1;
   localparam int P_LATE  = 6;
   localparam int P_LONG  = 7;
   localparam int P_MCAST = 10;
   localparam int P_RUNT  = 11;
   localparam int P_TYPE  = 12;
   localparam int P_DERR  = 14;
   localparam int P_ESUM  = 15;
   localparam int P_LEN   = 16;
   localparam int P_OWN   = 31;

   typedef enum logic [2:0] {
      S_GET,
      S_RUN,
      S_FETCH,
      S_WB,
      S_DROP
   } rxd_state_e;

   typedef struct packed {
      logic       ovf;
      logic       crc;
      logic       late;
      logic       toolong;
      logic       mcast;
      logic [1:0] dtype;
   } rxd_flags_t;

endpackage

// File: rtl/rxd_cap_track.sv
module rxd_cap_track
   import rxd_pkg::*;
#(
   parameter int BCNT_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              carry,
   input  logic              take,
   input  logic [BCNT_W-1:0] b1_cnt,
   input  logic [BCNT_W-1:0] b2_cnt,
   output logic              full,
   output logic [LEN_W-1:0]  len
);
   localparam int CAP_W = BCNT_W + 1;
   localparam logic [LEN_W-1:0] LEN_MAX = '1;

   logic [CAP_W-1:0] cap_q, used_q;
   logic [LEN_W-1:0] len_q, len_inc;

   assign len_inc = (len_q == LEN_MAX) ? len_q : len_q + LEN_W'(1);
   assign full    = (used_q >= cap_q);
   assign len     = len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= '0;
         used_q <= '0;
         len_q  <= '0;
      end else if (load) begin
         cap_q  <= {1'b0, b1_cnt} + {1'b0, b2_cnt};
         used_q <= carry ? CAP_W'(1) : '0;
         len_q  <= carry ? len_inc : '0;
      end else if (take) begin
         used_q <= used_q + CAP_W'(1);
         len_q  <= len_inc;
      end
   end

   // R9
   len_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && !carry) |=> len_q >= $past(len_q));

endmodule

// File: rtl/rxd_stat_word.sv
module rxd_stat_word
   import rxd_pkg::*;
#(
   parameter int RUNT_MIN = 64
) (
   input  logic             last,
   input  logic             derr,
   input  rxd_flags_t       fl,
   input  logic [LEN_W-1:0] len,
   output logic [31:0]      word
);
   logic runt;

   assign runt = (int'(len) < RUNT_MIN);

   always_comb begin
      word = '0;
      if (last) begin
         word[P_LEN +: LEN_W] = len;
         word[P_OVF]          = fl.ovf;
         word[P_CRC]          = fl.crc;
         word[P_LATE]         = fl.late;
         word[P_LONG]         = fl.toolong;
         word[P_MCAST]        = fl.mcast;
         word[P_TYPE +: 2]    = fl.dtype;
         word[P_RUNT]         = runt;
         word[P_DERR]         = derr;
         word[P_ESUM]         = fl.ovf | fl.crc | fl.late | fl.toolong | runt | derr;
      end
      word[P_OWN] = 1'b0;
   end

endmodule

// File: rtl/rx_desc_status_wb.sv
module rx_desc_status_wb
   import rxd_pkg::*;
#(
   parameter int BCNT_W   = 11,
   parameter int RUNT_MIN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_byte_vld,
   input  logic              rx_eof,
   input  logic              rx_ovf,
   input  logic              rx_crc_err,
   input  logic              rx_late_col,
   input  logic              rx_too_long,
   input  logic              rx_mcast,
   input  logic [1:0]        rx_lb_type,
   output logic              rx_rdy,
   output logic              dsc_req,
   input  logic              dsc_vld,
   input  logic              dsc_own,
   input  logic [BCNT_W-1:0] dsc_b1_cnt,
   input  logic [BCNT_W-1:0] dsc_b2_cnt,
   output logic              wb_vld,
   output logic [31:0]       wb_status,
   input  logic              wb_ack
);
   generate
      if (BCNT_W < 1 || BCNT_W > 16) begin : g_bad_bcnt
         $error("BCNT_W must lie in 1..16");
      end
      if (RUNT_MIN < 1 || RUNT_MIN > (1 << LEN_W) - 1) begin : g_bad_runt
         $error("RUNT_MIN must fit the length field");
      end
   endgenerate

   rxd_state_e       state_q, ret_q;
   logic             last_q, derr_q;
   rxd_flags_t       fl_q;
   logic             full, load, carry, take;
   logic [LEN_W-1:0] len;

   assign rx_rdy  = (state_q == S_RUN) || (state_q == S_DROP);
   assign dsc_req = (state_q == S_GET) || (state_q == S_FETCH);
   assign wb_vld  = (state_q == S_WB);

   assign load  = dsc_vld && dsc_own && ((state_q == S_GET) || (state_q == S_FETCH));
   assign carry = (state_q == S_FETCH);
   assign take  = (state_q == S_RUN) && rx_byte_vld && !rx_eof && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_GET;
         ret_q   <= S_GET;
         last_q  <= 1'b0;
         derr_q  <= 1'b0;
         fl_q    <= '0;
      end else begin
         case (state_q)
            S_GET: begin
               if (dsc_vld && dsc_own) state_q <= S_RUN;
            end
            S_RUN: begin
               if (rx_eof) begin
                  fl_q    <= '{ovf: rx_ovf, crc: rx_crc_err, late: rx_late_col,
                               toolong: rx_too_long, mcast: rx_mcast, dtype: rx_lb_type};
                  derr_q  <= 1'b0;
                  last_q  <= 1'b1;
                  ret_q   <= S_GET;
                  state_q <= S_WB;
               end else if (rx_byte_vld && full) begin
                  state_q <= S_FETCH;
               end
            end
            S_FETCH: begin
               if (dsc_vld) begin
                  state_q <= S_WB;
                  if (dsc_own) begin
                     last_q <= 1'b0;
                     ret_q  <= S_RUN;
                  end else begin
                     last_q <= 1'b1;
                     derr_q <= 1'b1;
                     fl_q   <= '0;
                     ret_q  <= S_DROP;
                  end
               end
            end
            S_WB: begin
               if (wb_ack) state_q <= ret_q;
            end
            S_DROP: begin
               if (rx_eof) state_q <= S_GET;
            end
            default: state_q <= S_GET;
         endcase
      end
   end

   rxd_cap_track #(.BCNT_W(BCNT_W)) i_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .carry  (carry),
      .take   (take),
      .b1_cnt (dsc_b1_cnt),
      .b2_cnt (dsc_b2_cnt),
      .full   (full),
      .len    (len)
   );

   rxd_stat_word #(.RUNT_MIN(RUNT_MIN)) i_word (
      .last (last_q),
      .derr (derr_q),
      .fl   (fl_q),
      .len  (len),
      .word (wb_status)
   );

   // R10
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld && !wb_ack |=> wb_vld && $stable(wb_status));
   // R10
   wb_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld && wb_ack |=> !wb_vld);
   // R6
   nonlast_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld && !last_q |-> wb_status == 32'h0);
   // R7
   exhaust_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == S_FETCH && dsc_vld && !dsc_own |=> wb_vld && wb_status[P_DERR] && wb_status[P_ESUM]);
   // R8
   skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == S_GET && dsc_vld && !dsc_own |=> dsc_req && !rx_rdy && !wb_vld);

endmodule

// File: tb/test_rx_desc_status_wb.sv
`timescale 1ns/1ps
module test_rx_desc_status_wb;
   localparam int BW = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_byte_vld = 0, rx_eof = 0, rx_ovf = 0, rx_crc_err = 0;
   logic rx_late_col = 0, rx_too_long = 0, rx_mcast = 0;
   logic [1:0] rx_lb_type = 0;
   logic rx_rdy, dsc_req, wb_vld;
   logic dsc_vld = 0, dsc_own = 0, wb_ack = 0;
   logic [BW-1:0] dsc_b1_cnt = 0, dsc_b2_cnt = 0;
   logic [31:0] wb_status;

   int checks = 0, errors = 0;

   // descriptor queue served on request
   logic          dq_own [0:31];
   logic [BW-1:0] dq_b1 [0:31];
   logic [BW-1:0] dq_b2 [0:31];
   int dq_n = 0, dq_i = 0;

   // writeback log
   logic [31:0] wb_log [0:63];
   int wb_n = 0, ack_dly = 0, hold = 0, hold_seen = 0, stab_bad = 0;
   logic [31:0] cur;

   always #2 clk = ~clk;

   rx_desc_status_wb #(.BCNT_W(BW), .RUNT_MIN(64)) i_rx_desc_status_wb (
      .clk(clk), .rst_n(rst_n),
      .rx_byte_vld(rx_byte_vld), .rx_eof(rx_eof), .rx_ovf(rx_ovf),
      .rx_crc_err(rx_crc_err), .rx_late_col(rx_late_col), .rx_too_long(rx_too_long),
      .rx_mcast(rx_mcast), .rx_lb_type(rx_lb_type), .rx_rdy(rx_rdy),
      .dsc_req(dsc_req), .dsc_vld(dsc_vld), .dsc_own(dsc_own),
      .dsc_b1_cnt(dsc_b1_cnt), .dsc_b2_cnt(dsc_b2_cnt),
      .wb_vld(wb_vld), .wb_status(wb_status), .wb_ack(wb_ack)
   );

   initial begin
      forever begin
         @(negedge clk);
         dsc_vld = 1'b0;
         if (rst_n && dsc_req && dq_i < dq_n) begin
            dsc_own    = dq_own[dq_i];
            dsc_b1_cnt = dq_b1[dq_i];
            dsc_b2_cnt = dq_b2[dq_i];
            dsc_vld    = 1'b1;
            dq_i++;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         wb_ack = 1'b0;
         if (rst_n && wb_vld) begin
            if (hold == 0) cur = wb_status;
            else if (wb_status !== cur) stab_bad++;
            if (hold >= ack_dly) begin
               wb_ack = 1'b1;
               wb_log[wb_n] = cur;
               wb_n++;
               hold_seen = hold;
               hold = 0;
            end else begin
               hold++;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic [31:0] mk(int len, bit ovf, bit crc, bit late, bit tl,
                                      bit mc, bit [1:0] dt, bit de);
      logic [31:0] w;
      int l;
      bit runt;
      l = (len > 32767) ? 32767 : len;
      runt = (l < 64);
      w = '0;
      w[30:16] = l[14:0];
      w[0] = ovf; w[1] = crc; w[6] = late; w[7] = tl;
      w[10] = mc; w[13:12] = dt; w[11] = runt; w[14] = de;
      w[15] = ovf | crc | late | tl | runt | de;
      return w;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic push(bit own, int b1, int b2);
      dq_own[dq_n] = own;
      dq_b1[dq_n]  = b1[BW-1:0];
      dq_b2[dq_n]  = b2[BW-1:0];
      dq_n++;
   endtask

   task automatic send_bytes(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_byte_vld = 1'b0;
         while (!rx_rdy) @(negedge clk);
         rx_byte_vld = 1'b1;
      end
      @(negedge clk);
      rx_byte_vld = 1'b0;
   endtask

   task automatic send_eof(bit ovf, bit crc, bit late, bit tl, bit mc, bit [1:0] dt);
      while (!rx_rdy) @(negedge clk);
      rx_eof = 1; rx_ovf = ovf; rx_crc_err = crc; rx_late_col = late;
      rx_too_long = tl; rx_mcast = mc; rx_lb_type = dt;
      @(negedge clk);
      rx_eof = 0; rx_ovf = 0; rx_crc_err = 0; rx_late_col = 0;
      rx_too_long = 0; rx_mcast = 0; rx_lb_type = 0;
   endtask

   task automatic wait_wb(int n);
      while (wb_n < n) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R11 wb_vld", {31'b0, wb_vld}, 32'd0);
      check("R11 rx_rdy", {31'b0, rx_rdy}, 32'd0);
      check("R11 dsc_req", {31'b0, dsc_req}, 32'd1);
   endtask

   task automatic t_basic;
      int b;
      b = wb_n;
      push(1, 60, 100);
      send_bytes(100);
      send_eof(0, 0, 0, 0, 1, 2'b01);
      wait_wb(b + 1);
      check("R2 basic word", wb_log[b], mk(100, 0, 0, 0, 0, 1, 2'b01, 0));
      check("R1 own clear", {31'b0, wb_log[b][31]}, 32'd0);
   endtask

   task automatic t_errors;
      int b;
      b = wb_n;
      push(1, 200, 0);
      send_bytes(70);
      send_eof(1, 0, 0, 0, 0, 2'b10);
      push(1, 100, 100);
      send_bytes(70);
      send_eof(0, 0, 1, 0, 0, 2'b11);
      push(1, 0, 200);
      send_bytes(70);
      send_eof(0, 1, 0, 1, 0, 2'b00);
      wait_wb(b + 3);
      check("R3 overflow", wb_log[b], mk(70, 1, 0, 0, 0, 0, 2'b10, 0));
      check("R3 late collision", wb_log[b+1], mk(70, 0, 0, 1, 0, 0, 2'b11, 0));
      check("R3 crc and too long", wb_log[b+2], mk(70, 0, 1, 0, 1, 0, 2'b00, 0));
   endtask

   task automatic t_runt;
      int b, q;
      b = wb_n;
      push(1, 40, 24);
      send_bytes(63);
      send_eof(0, 0, 0, 0, 0, 2'b00);
      q = dq_i;
      push(1, 40, 24);
      send_bytes(64);
      send_eof(0, 0, 0, 0, 0, 2'b00);
      wait_wb(b + 2);
      check("R4 runt at 63", wb_log[b], mk(63, 0, 0, 0, 0, 0, 2'b00, 0));
      check("R4 no runt at 64", wb_log[b+1], mk(64, 0, 0, 0, 0, 0, 2'b00, 0));
      check("R5 exact fit one descriptor", dq_i - q, 1);
   endtask

   task automatic t_spill;
      int b;
      b = wb_n;
      push(1, 30, 20);
      push(1, 40, 10);
      push(1, 100, 100);
      send_bytes(120);
      send_eof(0, 0, 0, 0, 1, 2'b00);
      wait_wb(b + 3);
      check("R6 first non-last", wb_log[b], 32'h0);
      check("R6 second non-last", wb_log[b+1], 32'h0);
      check("R5 spill final length", wb_log[b+2], mk(120, 0, 0, 0, 0, 1, 2'b00, 0));
   endtask

   task automatic t_exhaust;
      int b;
      b = wb_n;
      push(1, 50, 30);
      push(0, 500, 500);
      send_bytes(100);
      send_eof(0, 1, 0, 0, 1, 2'b01);
      wait_wb(b + 1);
      check("R7 truncated final", wb_log[b], mk(80, 0, 0, 0, 0, 0, 2'b00, 1));
      push(0, 300, 0);
      repeat (5) @(negedge clk);
      check("R8 skip rdy low", {31'b0, rx_rdy}, 32'd0);
      check("R8 skip req high", {31'b0, dsc_req}, 32'd1);
      check("R8 skip no writeback", wb_n, b + 1);
      push(1, 100, 0);
      send_bytes(70);
      send_eof(0, 0, 0, 0, 0, 2'b00);
      wait_wb(b + 2);
      check("R7 next frame clean", wb_log[b+1], mk(70, 0, 0, 0, 0, 0, 2'b00, 0));
   endtask

   task automatic t_hold;
      int b;
      b = wb_n;
      ack_dly = 4;
      stab_bad = 0;
      push(1, 80, 0);
      send_bytes(66);
      send_eof(0, 0, 0, 0, 1, 2'b11);
      wait_wb(b + 1);
      ack_dly = 0;
      check("R10 held cycles", hold_seen, 4);
      check("R10 word stable", stab_bad, 0);
      check("R10 held word", wb_log[b], mk(66, 0, 0, 0, 0, 1, 2'b11, 0));
      check("R1 own clear held", {31'b0, wb_log[b][31]}, 32'd0);
   endtask

   task automatic t_sat;
      int b;
      b = wb_n;
      push(1, 32767, 32767);
      send_bytes(32800);
      send_eof(0, 0, 0, 1, 0, 2'b00);
      wait_wb(b + 1);
      check("R9 saturated length", wb_log[b], mk(32767, 0, 0, 0, 1, 0, 2'b00, 0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_basic;
      t_errors;
      t_runt;
      t_spill;
      t_exhaust;
      t_hold;
      t_sat;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule